// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds one status flag for each interrupt vector of an interrupt controller, for vector numbers 16 through 255. A flag is raised by its source and lowered according to that source's detection style. An edge-style flag latches a request event and keeps it until the interrupt destination acknowledges that vector or software clears it. A level-style flag mirrors its request line and nothing else can change it.

Peripheral sources arrive as request lines, and each one's detection style is fixed by a parameter mask. Six external pins feed a fixed run of vectors instead. Each pin has a two-bit mode input that selects low-level, falling-edge, rising-edge or both-edge detection, after a two-flop synchroniser. A byte-wide register port reads and writes the flags, one byte per vector at an address equal to the vector number. A per-vector input marks sources whose requests are served by the data-transfer engine instead of the CPU. The flag vector goes to downstream priority logic.

Top module: `irq_flag_bank`

## Requirements
- R1: The register at byte address v (16 to 255) returns the flag of vector v in bit 0, and bits 7 to 1 always read 0. Addresses 0 to 15 read as 0. The read path is combinational.
- R2: Bits 7 to 1 of a written byte have no effect. Writing 1 to bit 0 of an edge-style flag neither sets it nor changes it.
- R3: An edge-style peripheral flag is set on the clock edge where its request input is 1, and it stays set after the request returns to 0.
- R4: An acknowledge (valid with a vector number) clears only the edge-style flag of that vector, on the next clock edge.
- R5: Writing 0 to bit 0 clears an edge-style flag when the vector's transfer-engine input is 0. The write is ignored when that input is 1.
- R6: A level-style flag equals, after each clock edge, its request as sampled on that edge, and acknowledge has no effect on it. With the default mask, vectors 100 to 103 are level-style peripheral sources.
- R7: Writes of 0 or 1 to a level-style flag are ignored.
- R8: Pin i drives vector 64+i. Its mode field, bits 2i+1:2i of the mode input, is 00 = level (active when the pin is low), 01 = falling edge, 10 = rising edge, 11 = both edges. The peripheral request input of a pin vector is ignored.
- R9: A pin change at the input shows in the flag after the third rising clock edge, not earlier.
- R10: When a set event and a clear (acknowledge or allowed write of 0) reach an edge-style flag on the same edge, the flag ends up set.
- R11: A synchronous active-low reset clears every flag and treats all pins as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| periph_req | input | 240 | Peripheral request per vector, bit v-16 for vector v |
| pin_n | input | 6 | External request pins, asynchronous |
| pin_mode | input | 12 | Two-bit detection mode per pin |
| dest_xfer | input | 240 | Per vector: 1 when the transfer engine serves the request |
| ack_valid | input | 1 | Destination accepts an interrupt this cycle |
| ack_vec | input | 8 | Vector number being accepted |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address (equals vector number) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| flags | output | 240 | Flag vector, bit v-16 for vector v |

## Verification
On every cycle, the assertions check each flag cell's own rules. An edge flag holds unless a clear reaches it, a set always lands, and acknowledge clears it. A write is ignored when the request goes to the transfer engine or when it writes 1, and a level flag tracks its request. Only the bench scenarios can show the end-to-end pin behaviour. These cover the mapping from mode code to detection, the three-edge synchroniser latency, the address decode and reserved-bit readback, and the fact that acknowledges and writes touch only the addressed vector. A cycle model run under random traffic compares the whole flag vector on every cycle.

// File: rtl/irq_bank_pkg.sv
// Package: shared types and helpers for the interrupt request flag bank.
// Assumes nothing beyond IEEE 1800-2017; holds the pin mode encoding.
package irq_bank_pkg;

    typedef enum logic [1:0] {
        PM_LOW_LEVEL = 2'b00,
        PM_FALL      = 2'b01,
        PM_RISE      = 2'b10,
        PM_BOTH      = 2'b11
    } pin_mode_e;

    // True when a pin mode code selects level detection.
    function automatic logic mode_is_level(input logic [1:0] code);
        return code == PM_LOW_LEVEL;
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
// Module: irq_pin_detect
// Synchronises the asynchronous external request pins with two flops and
// turns each into a request for its flag cell: in level mode the inverted
// synchronised pin, in edge modes a one-cycle pulse on the chosen transition.
// Assumes pins idle high and that the mode inputs are quasi-static.
module irq_pin_detect
    import irq_bank_pkg::*;
#(
    parameter int NUM_PINS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_n,
    input  logic [2*NUM_PINS-1:0] pin_mode,
    output logic [NUM_PINS-1:0]   pin_level,
    output logic [NUM_PINS-1:0]   pin_req
);

    logic [NUM_PINS-1:0] sync_a;
    logic [NUM_PINS-1:0] sync_b;
    logic [NUM_PINS-1:0] last_b;

    // Two-flop synchroniser plus one history stage for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '1;
            sync_b <= '1;
            last_b <= '1;
        end else begin
            sync_a <= pin_n;
            sync_b <= sync_a;
            last_b <= sync_b;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [1:0] code;
        logic       fell;
        logic       rose;

        assign code = pin_mode[2*p +: 2];
        assign fell = last_b[p] & ~sync_b[p];
        assign rose = ~last_b[p] & sync_b[p];

        // Select the request seen by the flag cell from the pin's mode code.
        always_comb begin
            pin_level[p] = mode_is_level(code);
            unique case (code)
                PM_LOW_LEVEL: pin_req[p] = ~sync_b[p];
                PM_FALL:      pin_req[p] = fell;
                PM_RISE:      pin_req[p] = rose;
                default:      pin_req[p] = fell | rose;
            endcase
        end

        // A level-mode pin request always mirrors the inverted synchronised pin.
        assert_pin_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (code == PM_LOW_LEVEL) |-> (pin_req[p] == ~sync_b[p]));
    end

endmodule

// File: rtl/irq_flag_cell.sv
// Module: irq_flag_cell
// One interrupt status flag. Edge style: sticky, set by a request pulse,
// cleared by acknowledge or by an allowed write of 0, set wins over clear.
// Level style: registered copy of the request, untouched by ack and writes.
// Assumes ack_hit and wr_hit are already decoded for this vector.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic src,
    input  logic ack_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic to_xfer,
    output logic flag
);

    logic sw_clear;
    logic any_clear;

    // Software may clear only with a 0 and only for CPU-served requests.
    always_comb begin
        sw_clear  = wr_hit & ~wr_bit & ~to_xfer;
        any_clear = ack_hit | sw_clear;
    end

    // Flag update by detection style.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (level_mode) begin
            flag <= src;
        end else begin
            flag <= src | (flag & ~any_clear);
        end
    end

    assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && src) |=> flag);

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && flag && !ack_hit && !wr_hit) |=> flag);

    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && ack_hit && !src) |=> !flag);

    assert_xfer_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && flag && wr_hit && to_xfer && !ack_hit) |=> flag);

    assert_write_one_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !flag && !src && wr_hit && wr_bit) |=> !flag);

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (flag == $past(src)));

endmodule

// File: rtl/irq_read_mux.sv
// Module: irq_read_mux
// Combinational readback: returns the addressed vector's flag in bit 0,
// zero in all other bits and for addresses below the first vector.
module irq_read_mux #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int VEC_FIRST = 16,
    parameter int NUM_VEC   = 240
) (
    input  logic [NUM_VEC-1:0] flags,
    input  logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(VEC_FIRST);

    logic [ADDR_W-1:0] offset;
    logic              in_range;

    // Decode the window and pick the flag bit.
    always_comb begin
        offset   = addr - FIRST_A;
        in_range = (addr >= FIRST_A) && (int'(offset) < NUM_VEC);
        rdata    = '0;
        if (in_range) begin
            rdata[0] = flags[offset];
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank (top)
// Bank of per-vector interrupt status flags with edge/level detection,
// external pin sources, acknowledge clearing and a byte register port.
// Assumes byte address equals vector number and one ack per cycle.
module irq_flag_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int VEC_FIRST    = 16,
    parameter int VEC_LAST     = 255,
    parameter int NUM_PINS     = 6,
    parameter int PIN_VEC_BASE = 64,
    parameter logic [VEC_LAST-VEC_FIRST:0] LEVEL_SRC_MASK =
        (VEC_LAST-VEC_FIRST+1)'(4'hF) << (100 - VEC_FIRST)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [VEC_LAST-VEC_FIRST:0]   periph_req,
    input  logic [NUM_PINS-1:0]           pin_n,
    input  logic [2*NUM_PINS-1:0]         pin_mode,
    input  logic [VEC_LAST-VEC_FIRST:0]   dest_xfer,
    input  logic                          ack_valid,
    input  logic [ADDR_W-1:0]             ack_vec,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [VEC_LAST-VEC_FIRST:0]   flags
);

    localparam int NUM_VEC = VEC_LAST - VEC_FIRST + 1;

    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] pin_req;

    irq_pin_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n),
        .pin_mode  (pin_mode),
        .pin_level (pin_level),
        .pin_req   (pin_req)
    );

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        localparam int              VNUM   = VEC_FIRST + i;
        localparam logic [ADDR_W-1:0] VADDR = ADDR_W'(VNUM);
        localparam bit              IS_PIN = (VNUM >= PIN_VEC_BASE) &&
                                             (VNUM < PIN_VEC_BASE + NUM_PINS);

        logic lvl;
        logic src;
        logic ack_hit;
        logic wr_hit;

        if (IS_PIN) begin : g_src_pin
            assign lvl = pin_level[VNUM - PIN_VEC_BASE];
            assign src = pin_req[VNUM - PIN_VEC_BASE];
        end else begin : g_src_periph
            assign lvl = LEVEL_SRC_MASK[i];
            assign src = periph_req[i];
        end

        assign ack_hit = ack_valid & (ack_vec == VADDR);
        assign wr_hit  = bus_wr & (bus_addr == VADDR);

        irq_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (lvl),
            .src        (src),
            .ack_hit    (ack_hit),
            .wr_hit     (wr_hit),
            .wr_bit     (bus_wdata[0]),
            .to_xfer    (dest_xfer[i]),
            .flag       (flags[i])
        );
    end

    irq_read_mux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .VEC_FIRST (VEC_FIRST),
        .NUM_VEC   (NUM_VEC)
    ) u_rd (
        .flags (flags),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );

endmodule

// File: tb/irq_flag_bank_bench.sv
module irq_flag_bank_bench;

    localparam int NV = 240;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NV-1:0] periph_req;
    logic [5:0]    pin_n;
    logic [11:0]   pin_mode;
    logic [NV-1:0] dest_xfer;
    logic          ack_valid;
    logic [7:0]    ack_vec;
    logic          bus_wr;
    logic [7:0]    bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    logic [NV-1:0] flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model state
    logic [NV-1:0] m_flag;
    logic [5:0]    m_s1, m_s2, m_prev;

    always #2 clk = ~clk;

    irq_flag_bank u_irq_flag_bank (
        .clk (clk), .rst_n (rst_n), .periph_req (periph_req), .pin_n (pin_n),
        .pin_mode (pin_mode), .dest_xfer (dest_xfer), .ack_valid (ack_valid),
        .ack_vec (ack_vec), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .flags (flags)
    );

    function automatic bit is_level_vec(int v);
        if (v >= 64 && v < 70) return pin_mode[2*(v-64) +: 2] == 2'b00;
        return (v >= 100 && v <= 103);
    endfunction

    function automatic bit pin_src(int p);
        case (pin_mode[2*p +: 2])
            2'b00:   return ~m_s2[p];
            2'b01:   return m_prev[p] & ~m_s2[p];
            2'b10:   return ~m_prev[p] & m_s2[p];
            default: return m_prev[p] ^ m_s2[p];
        endcase
    endfunction

    task automatic model_edge();
        logic [NV-1:0] nf;
        if (!rst_n) begin
            m_flag = '0; m_s1 = '1; m_s2 = '1; m_prev = '1;
            return;
        end
        for (int i = 0; i < NV; i++) begin
            int v = i + 16;
            bit s, clr;
            s = (v >= 64 && v < 70) ? pin_src(v-64) : periph_req[i];
            clr = (ack_valid && ack_vec == 8'(v)) ||
                  (bus_wr && bus_addr == 8'(v) && !bus_wdata[0] && !dest_xfer[i]);
            if (is_level_vec(v)) nf[i] = s;
            else                 nf[i] = s | (m_flag[i] & ~clr);
        end
        m_flag = nf;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_n;
    endtask

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: model at posedge, compare at negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(flags === m_flag, "R3 R6 model", 256'(flags), 256'(m_flag));
    endtask

    task automatic idle();
        periph_req = '0; ack_valid = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic check_read(int a, logic [7:0] exp, string req);
        bus_addr = 8'(a);
        #1;
        chk(bus_rdata === exp, req, 256'(bus_rdata), 256'(exp));
    endtask

    task automatic bit_chk(int v, bit exp, string req);
        chk(flags[v-16] === exp, req, 256'(flags[v-16]), 256'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; pin_n = '1; pin_mode = {6{2'b01}}; ack_vec = 0; bus_addr = 0;
        idle();
        for (int i = 0; i < NV; i++) dest_xfer[i] = ($urandom % 4) == 0;
        dest_xfer[31-16] = 1'b1;
        dest_xfer[32-16] = 1'b0;
        dest_xfer[33-16] = 1'b0;
        repeat (3) tick();
        rst_n = 1;
        // R11: reset state
        chk(flags === '0, "R11", 256'(flags), 256'(0));
        // R1: low addresses and an idle flag read 0
        check_read(5, 8'h00, "R1");
        check_read(20, 8'h00, "R1");
        // R3: edge set and sticky
        periph_req[30-16] = 1; tick(); idle(); tick();
        bit_chk(30, 1, "R3");
        check_read(30, 8'h01, "R1");
        // R2: write all ones to a set flag, write 1 to a clear flag
        bus_wr = 1; bus_addr = 30; bus_wdata = 8'hFF; tick(); idle();
        bit_chk(30, 1, "R2");
        bus_wr = 1; bus_addr = 31; bus_wdata = 8'hFE | 8'h01; tick(); idle();
        bit_chk(31, 0, "R2");
        // R4: ack clears only its vector
        periph_req[31-16] = 1; tick(); idle();
        ack_valid = 1; ack_vec = 30; tick(); idle();
        bit_chk(30, 0, "R4");
        bit_chk(31, 1, "R4");
        // R5: write 0 ignored for transfer-engine vector, honoured for CPU vector
        bus_wr = 1; bus_addr = 31; bus_wdata = 8'h00; tick(); idle();
        bit_chk(31, 1, "R5");
        periph_req[32-16] = 1; tick(); idle();
        bus_wr = 1; bus_addr = 32; bus_wdata = 8'hFE; tick(); idle();
        bit_chk(32, 0, "R5");
        // R6: level flag follows request, ack has no effect
        periph_req[100-16] = 1; tick();
        bit_chk(100, 1, "R6");
        ack_valid = 1; ack_vec = 100; tick();
        bit_chk(100, 1, "R6");
        ack_valid = 0; periph_req[100-16] = 0; tick();
        bit_chk(100, 0, "R6");
        // R7: writes to level flag ignored
        periph_req[100-16] = 1; bus_wr = 1; bus_addr = 100; bus_wdata = 0; tick();
        bit_chk(100, 1, "R7");
        periph_req[100-16] = 0; bus_wdata = 1; tick(); idle();
        bit_chk(100, 0, "R7");
        // R10: set and ack on same edge -> set
        periph_req[33-16] = 1; ack_valid = 1; ack_vec = 33; tick(); idle();
        bit_chk(33, 1, "R10");
        // R9 + R8 falling edge on pin 0 (vector 64); periph request for 64 ignored
        periph_req[64-16] = 1; tick(); idle(); tick();
        bit_chk(64, 0, "R8");
        pin_n[0] = 0; tick(); tick();
        bit_chk(64, 0, "R9");
        tick();
        bit_chk(64, 1, "R9");
        // R8 rising edge on pin 1
        pin_mode[3:2] = 2'b10; pin_n[1] = 0; repeat (4) tick();
        bit_chk(65, 0, "R8");
        pin_n[1] = 1; repeat (3) tick();
        bit_chk(65, 1, "R8");
        // R8 level on pin 2: active low, follows
        pin_mode[5:4] = 2'b00; tick();
        bit_chk(66, 0, "R8");
        pin_n[2] = 0; repeat (3) tick();
        bit_chk(66, 1, "R8");
        pin_n[2] = 1; repeat (3) tick();
        bit_chk(66, 0, "R8");
        // R8 both edges on pin 3
        pin_mode[7:6] = 2'b11; pin_n[3] = 0; repeat (3) tick();
        bit_chk(67, 1, "R8");
        ack_valid = 1; ack_vec = 67; tick(); idle();
        pin_n[3] = 1; repeat (3) tick();
        bit_chk(67, 1, "R8");
        // random traffic against the model (R3..R10)
        for (int c = 0; c < 3000; c++) begin
            idle();
            for (int i = 0; i < NV; i++) begin
                if (i + 16 >= 100 && i + 16 <= 103)
                    periph_req[i] = (($urandom % 8) == 0) ? ~flags[i] : flags[i];
                else
                    periph_req[i] = ($urandom % 64) == 0;
            end
            if (($urandom % 16) == 0) pin_n[$urandom % 6] ^= 1'b1;
            if (($urandom % 200) == 0) pin_mode = 12'($urandom);
            ack_valid = ($urandom % 3) == 0;
            ack_vec   = 8'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 8'($urandom);
            bus_wdata = 8'($urandom);
            tick();
            if ((c % 50) == 0) begin
                int a = $urandom % 256;
                check_read(a, (a >= 16) ? {7'b0, m_flag[a-16]} : 8'h00, "R1");
            end
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule